// File: doc/BRIEF.md
# One-Time-Programmable Trim Fuse Bank

This block holds the trim storage of a programmable linear sensor as four sticky registers. Each register has a permanent fuse image, which only gains bits, and a volatile try overlay. The codes the analog trim circuits receive are the bitwise OR of the two. A programming controller writes trial codes into the overlays. Once it has found a good code, it sets fuses one bit per request. A two-step lock seals the fuse image for good. A serial read-back port returns any single fuse bit.

The four registers use these index values:

| Index | Register | Width | Field layout |
|-------|----------|-------|--------------|
| 0 | Sensitivity | 7 bits | Bits 0..5 are the user code. Bit 6 is reserved. |
| 1 | Offset | 6 bits | Bits 0..4 are the offset code. Bit 5 disables the output clamp. |
| 2 | Factory | `FACT_W` bits | Reserved for factory trim. |
| 3 | Margin/lock | 9 bits | Bit 0 is margin-low, bit 1 the margin comparator, bit 2 margin-high, bit 8 the lock-arm bit. |

A sequencer drives the blow requests through these states:

| State | What happens |
|-------|--------------|
| `ST_IDLE` | Waits for a request. |
| `ST_BURN` | Holds the latched target for `BURN_CYCLES` cycles. The fuse is set on the last of these cycles. |
| `ST_DONE` | Pulses `blow_done` for one cycle. |
| `ST_REJECT` | Pulses `blow_err` for one cycle. |
| `ST_SEALED` | Final lock is set. The sequencer stays here permanently. |

The transitions are named as follows:

| Transition | From | To | Condition |
|------------|------|----|-----------|
| accept | `ST_IDLE` | `ST_BURN` | A valid request arrives, or any request arrives once the lock-arm bit is blown. |
| refuse | `ST_IDLE` | `ST_REJECT` | The request has an invalid target. |
| fire | `ST_BURN` | `ST_DONE` | The burn count is complete. |
| release | `ST_DONE` or `ST_REJECT` | `ST_IDLE` | Always, unless the seal applies. |
| seal | `ST_DONE` | `ST_SEALED` | The hidden final fuse is now set. |
| power-cycle | any state | `ST_IDLE` | `pwr_cycle` is high and the hidden final fuse is not set. |
| power-cycle | any state | `ST_SEALED` | `pwr_cycle` is high and the hidden final fuse is set. |

Top module: `otp_trim_bank`

## Requirements
- R1: A valid blow request accepted in idle sets the addressed fuse at the clock edge `BURN_CYCLES` edges after the acceptance edge. In the cycle that follows that edge, `blow_done` is high for exactly one cycle and the new code is visible on the trim outputs.
- R2: The following blow requests are refused while the lock-arm bit is unblown:
  - register 2, any bit;
  - register 0, bit 6 or above;
  - any bit index at or beyond the register's width.
  
  A refused request raises `blow_err` for the one cycle after the acceptance edge and changes no fuse.
- R3: Fuse bits never return to 0, and later blows add bits: blowing bit 1 and then bit 0 gives code 3.
- R4: At most one fuse bit in the whole bank changes per clock cycle.
- R5: Offset register bits 0..4 drive `offs_code`, and bit 5 drives `clamp_dis`.
- R6: Margin register bits 0, 1, 2 and 8 appear at the same positions of `margin_code`. The fuse at bit 8 also drives `lock_armed`.
- R7: A try write stores the register's code in its overlay at the next edge. Each trim output is then the OR of fuse and overlay. Try writes to register 2 have no effect.
- R8: `pwr_cycle` clears every try overlay and aborts a blow in progress without setting its fuse. Fuses keep their values.
- R9: When `lock_armed` is 1, the next accepted request sets the hidden final fuse (`final_lock`) instead of the addressed bit. This happens with the same timing and `blow_done` pulse as R1.
- R10: Once `final_lock` is 1, the following all have no effect:
  - blow requests, which raise neither `blow_done` nor `blow_err`;
  - try writes;
  - power cycles.
  
  Read-back still works.
- R11: `rd_data` shows the fuse bit selected by `rd_reg` and `rd_bit` one cycle after they are applied. It reflects the fuse image only, never the overlay, and gives 0 for a bit index of 9 or more.
- R12: Requests arriving while `busy` is high are ignored, and the latched target stays unchanged until the blow completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low initialisation of the whole bank, fuses included |
| pwr_cycle | input | 1 | Clears volatile state |
| blow_req | input | 1 | Request to set one fuse |
| blow_reg | input | 2 | Register index of the request |
| blow_bit | input | 4 | Bit index of the request |
| try_we | input | 1 | Try overlay write strobe |
| try_reg | input | 2 | Register index of the try write |
| try_code | input | 9 | Try code, taken LSB-aligned to the register width |
| rd_reg | input | 2 | Read-back register index |
| rd_bit | input | 4 | Read-back bit index |
| sens_code | output | 7 | Effective sensitivity code |
| offs_code | output | 5 | Effective offset code |
| clamp_dis | output | 1 | Effective clamp-disable bit |
| factory_code | output | FACT_W | Effective factory trim code |
| margin_code | output | 9 | Effective margin/lock code |
| lock_armed | output | 1 | Lock-arm fuse is blown |
| final_lock | output | 1 | Hidden final fuse is blown |
| busy | output | 1 | Sequencer is handling a request |
| blow_done | output | 1 | One-cycle pulse when a blow completes |
| blow_err | output | 1 | One-cycle pulse when a request is refused |
| rd_data | output | 1 | Registered read-back bit |

## Verification
Each result falls due at a fixed number of cycles after its stimulus:

| Stimulus | Result | Due |
|----------|--------|-----|
| Blow request | New fuse value and `blow_done` | `BURN_CYCLES` edges after the acceptance edge; `busy` clears one edge later |
| Blow request | Refusal pulse | The cycle right after the acceptance edge |
| Try write, read-back select, power cycle | Their effect | One edge after the stimulus |

The bench drives inputs on falling edges and counts falling edges from the acceptance edge before sampling each result. In the cycles in between it also samples, to show that no early or stray pulses appear.

// File: rtl/otp_trim_pkg.sv
package otp_trim_pkg;
    localparam int NUM_REGS     = 4;
    localparam int MAX_W        = 9;
    localparam int IDX_W        = $clog2(MAX_W);
    localparam int REG_IDX_W    = $clog2(NUM_REGS);
    localparam int SENS_W       = 7;
    localparam int SENS_RSV_BIT = 6;
    localparam int OFFS_W       = 6;
    localparam int OFFS_CODE_W  = 5;
    localparam int MARG_W       = 9;
    localparam int LOCK_BIT     = 8;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_SENS = 2'd0,
        REG_OFFS = 2'd1,
        REG_FACT = 2'd2,
        REG_MARG = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURN,
        ST_DONE,
        ST_REJECT,
        ST_SEALED
    } blow_state_e;

    function automatic int reg_width(input int idx, input int fact_w);
        case (idx)
            0:       return SENS_W;
            1:       return OFFS_W;
            2:       return fact_w;
            default: return MARG_W;
        endcase
    endfunction
endpackage

// File: rtl/otp_trim_reg.sv
module otp_trim_reg
    import otp_trim_pkg::*;
#(
    parameter int WIDTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_cycle,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_bit,
    input  logic             try_en,
    input  logic [WIDTH-1:0] try_val,
    output logic [WIDTH-1:0] fuse_q,
    output logic [WIDTH-1:0] eff_q
);
    logic [WIDTH-1:0] try_q;
    logic [WIDTH-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        if (set_en && (int'(set_bit) < WIDTH)) begin
            set_mask = {{(WIDTH-1){1'b0}}, 1'b1} << set_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_q <= '0;
        end else begin
            fuse_q <= fuse_q | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            try_q <= '0;
        end else if (pwr_cycle) begin
            try_q <= '0;
        end else if (try_en) begin
            try_q <= try_val;
        end
    end

    assign eff_q = fuse_q | try_q;

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((fuse_q & $past(fuse_q)) == $past(fuse_q)));

    assert_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(fuse_q ^ $past(fuse_q)) <= 1));

    assert_try_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_cycle |=> (try_q == '0));
endmodule

// File: rtl/otp_blow_fsm.sv
module otp_blow_fsm
    import otp_trim_pkg::*;
#(
    parameter int BURN_CYCLES = 4,
    parameter int FACT_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_cycle,
    input  logic                 blow_req,
    input  logic [REG_IDX_W-1:0] blow_reg,
    input  logic [IDX_W-1:0]     blow_bit,
    input  logic                 lock_armed,
    output logic                 fuse_set,
    output logic [REG_IDX_W-1:0] set_reg,
    output logic [IDX_W-1:0]     set_bit,
    output logic                 final_lock,
    output logic                 busy,
    output logic                 blow_done,
    output logic                 blow_err
);
    localparam int CNT_W = (BURN_CYCLES > 1) ? $clog2(BURN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BURN_CYCLES - 1);

    blow_state_e            state, state_nx;
    logic [CNT_W-1:0]       cnt;
    logic [REG_IDX_W-1:0]   tgt_reg;
    logic [IDX_W-1:0]       tgt_bit;
    logic                   tgt_final;
    logic                   final_q;
    logic                   fire;
    logic                   req_bad;

    function automatic logic target_invalid(input logic [REG_IDX_W-1:0] r,
                                            input logic [IDX_W-1:0] b);
        case (r)
            REG_SENS: return (int'(b) >= SENS_RSV_BIT);
            REG_OFFS: return (int'(b) >= OFFS_W);
            REG_FACT: return 1'b1;
            default:  return (int'(b) >= MARG_W);
        endcase
    endfunction

    assign req_bad = !lock_armed && target_invalid(blow_reg, blow_bit);
    assign fire    = (state == ST_BURN) && (cnt == CNT_LAST) && !pwr_cycle;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (pwr_cycle) begin
            state_nx = final_q ? ST_SEALED : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (blow_req) state_nx = req_bad ? ST_REJECT : ST_BURN;
                ST_BURN:   if (cnt == CNT_LAST) state_nx = ST_DONE;
                ST_DONE:   state_nx = final_q ? ST_SEALED : ST_IDLE;
                ST_REJECT: state_nx = ST_IDLE;
                ST_SEALED: state_nx = ST_SEALED;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // target latch, burn counter and hidden final fuse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            tgt_reg   <= '0;
            tgt_bit   <= '0;
            tgt_final <= 1'b0;
            final_q   <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && blow_req && !pwr_cycle) begin
                tgt_reg   <= blow_reg;
                tgt_bit   <= blow_bit;
                tgt_final <= lock_armed;
                cnt       <= '0;
            end else if (state == ST_BURN) begin
                cnt <= cnt + 1'b1;
            end
            if (fire && tgt_final) begin
                final_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        blow_done = 1'b0;
        blow_err  = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_BURN:   busy = 1'b1;
            ST_DONE:   begin busy = 1'b1; blow_done = 1'b1; end
            ST_REJECT: begin busy = 1'b1; blow_err  = 1'b1; end
            ST_SEALED: busy = 1'b0;
            default:   busy = 1'b0;
        endcase
    end

    assign fuse_set   = fire && !tgt_final;
    assign set_reg    = tgt_reg;
    assign set_bit    = tgt_bit;
    assign final_lock = final_q;

    assert_done_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(blow_done && blow_err));

    assert_target_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURN) |=> ($stable(tgt_reg) && $stable(tgt_bit)));

    assert_sealed_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEALED) |-> (!fuse_set && !blow_done && !blow_err && final_q));

    assert_final_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(final_q) |-> final_q);
endmodule

// File: rtl/otp_readback.sv
module otp_readback
    import otp_trim_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_REGS-1:0][MAX_W-1:0]      fuse_all,
    input  logic [REG_IDX_W-1:0]                rd_reg,
    input  logic [IDX_W-1:0]                    rd_bit,
    output logic                                rd_data
);
    logic [MAX_W-1:0] row;

    assign row = fuse_all[rd_reg];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 1'b0;
        end else if (int'(rd_bit) < MAX_W) begin
            rd_data <= row[rd_bit];
        end else begin
            rd_data <= 1'b0;
        end
    end
endmodule

// File: rtl/otp_trim_bank.sv
module otp_trim_bank
    import otp_trim_pkg::*;
#(
    parameter int BURN_CYCLES = 4,
    parameter int FACT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_cycle,
    input  logic              blow_req,
    input  logic [1:0]        blow_reg,
    input  logic [3:0]        blow_bit,
    input  logic              try_we,
    input  logic [1:0]        try_reg,
    input  logic [8:0]        try_code,
    input  logic [1:0]        rd_reg,
    input  logic [3:0]        rd_bit,
    output logic [6:0]        sens_code,
    output logic [4:0]        offs_code,
    output logic              clamp_dis,
    output logic [FACT_W-1:0] factory_code,
    output logic [8:0]        margin_code,
    output logic              lock_armed,
    output logic              final_lock,
    output logic              busy,
    output logic              blow_done,
    output logic              blow_err,
    output logic              rd_data
);
    logic [NUM_REGS-1:0][MAX_W-1:0] fuse_all;
    logic                           fuse_set;
    logic [REG_IDX_W-1:0]           set_reg;
    logic [IDX_W-1:0]               set_bit;

    otp_blow_fsm #(
        .BURN_CYCLES (BURN_CYCLES),
        .FACT_W      (FACT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_cycle  (pwr_cycle),
        .blow_req   (blow_req),
        .blow_reg   (blow_reg),
        .blow_bit   (blow_bit),
        .lock_armed (lock_armed),
        .fuse_set   (fuse_set),
        .set_reg    (set_reg),
        .set_bit    (set_bit),
        .final_lock (final_lock),
        .busy       (busy),
        .blow_done  (blow_done),
        .blow_err   (blow_err)
    );

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam int W = reg_width(gi, FACT_W);
        logic [W-1:0] f;
        logic [W-1:0] e;
        logic         try_en;

        assign try_en = try_we && (try_reg == REG_IDX_W'(gi))
                        && (gi != int'(REG_FACT)) && !final_lock;

        otp_trim_reg #(.WIDTH(W)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .pwr_cycle (pwr_cycle && !final_lock),
            .set_en    (fuse_set && (set_reg == REG_IDX_W'(gi))),
            .set_bit   (set_bit),
            .try_en    (try_en),
            .try_val   (try_code[W-1:0]),
            .fuse_q    (f),
            .eff_q     (e)
        );

        assign fuse_all[gi] = MAX_W'(f);

        if (gi == 0) begin : g_sens
            assign sens_code = e;
        end else if (gi == 1) begin : g_offs
            assign offs_code = e[OFFS_CODE_W-1:0];
            assign clamp_dis = e[OFFS_W-1];
        end else if (gi == 2) begin : g_fact
            assign factory_code = e;
        end else begin : g_marg
            assign margin_code = e;
        end
    end

    assign lock_armed = fuse_all[REG_MARG][LOCK_BIT];

    otp_readback u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .fuse_all (fuse_all),
        .rd_reg   (rd_reg),
        .rd_bit   (rd_bit),
        .rd_data  (rd_data)
    );

    assert_frozen_after_seal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        final_lock |=> $stable(fuse_all));

    assert_factory_never_blown_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_armed && $past(!lock_armed)) |-> (fuse_all[REG_FACT] == '0));

    assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blow_done) |-> $past(busy));
endmodule

// File: tb/sim_otp_trim_bank.sv
module sim_otp_trim_bank;
    localparam int BURN = 4;
    localparam int FW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_cycle = 1'b0;
    logic          blow_req = 1'b0;
    logic [1:0]    blow_reg = '0;
    logic [3:0]    blow_bit = '0;
    logic          try_we = 1'b0;
    logic [1:0]    try_reg = '0;
    logic [8:0]    try_code = '0;
    logic [1:0]    rd_reg = '0;
    logic [3:0]    rd_bit = '0;
    logic [6:0]    sens_code;
    logic [4:0]    offs_code;
    logic          clamp_dis;
    logic [FW-1:0] factory_code;
    logic [8:0]    margin_code;
    logic          lock_armed, final_lock, busy, blow_done, blow_err, rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    otp_trim_bank #(.BURN_CYCLES(BURN), .FACT_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle),
        .blow_req(blow_req), .blow_reg(blow_reg), .blow_bit(blow_bit),
        .try_we(try_we), .try_reg(try_reg), .try_code(try_code),
        .rd_reg(rd_reg), .rd_bit(rd_bit),
        .sens_code(sens_code), .offs_code(offs_code), .clamp_dis(clamp_dis),
        .factory_code(factory_code), .margin_code(margin_code),
        .lock_armed(lock_armed), .final_lock(final_lock), .busy(busy),
        .blow_done(blow_done), .blow_err(blow_err), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // request presented for one cycle; returns just after the acceptance edge
    task automatic issue_blow(input logic [1:0] r, input logic [3:0] b);
        @(negedge clk);
        blow_req = 1'b1; blow_reg = r; blow_bit = b;
        @(negedge clk);
        blow_req = 1'b0;
    endtask

    task automatic blow_ok(input string req, input logic [1:0] r, input logic [3:0] b);
        issue_blow(r, b);
        chk(req, "busy during burn", int'(busy), 1);
        repeat (BURN - 1) begin
            @(negedge clk);
            chk(req, "no early done", int'(blow_done), 0);
        end
        @(negedge clk);
        chk(req, "done pulse", int'(blow_done), 1);
        @(negedge clk);
        chk(req, "done single cycle", int'(blow_done), 0);
    endtask

    task automatic t_reset;
        chk("R1", "reset sens", int'(sens_code), 0);
        chk("R5", "reset offs", int'(offs_code), 0);
        chk("R6", "reset margin", int'(margin_code), 0);
        chk("R9", "reset final", int'(final_lock), 0);
        chk("R12", "reset busy", int'(busy), 0);
    endtask

    task automatic t_sens_accumulate;
        blow_ok("R1", 2'd0, 4'd1);
        chk("R1", "sens after bit1", int'(sens_code), 2);
        blow_ok("R3", 2'd0, 4'd0);
        chk("R3", "sens accumulates to 3", int'(sens_code), 3);
    endtask

    task automatic t_busy_ignore;
        issue_blow(2'd0, 4'd2);
        blow_req = 1'b1; blow_reg = 2'd0; blow_bit = 4'd4;
        @(negedge clk);
        blow_req = 1'b0;
        repeat (BURN - 1) @(negedge clk);
        chk("R12", "done of first request", int'(blow_done), 1);
        chk("R12", "only first bit set", int'(sens_code), 7);
        repeat (BURN + 2) begin
            @(negedge clk);
            chk("R12", "no second done", int'(blow_done), 0);
        end
        chk("R12", "sens still 7", int'(sens_code), 7);
    endtask

    task automatic t_reject(input logic [1:0] r, input logic [3:0] b);
        issue_blow(r, b);
        chk("R2", "error pulse", int'(blow_err), 1);
        @(negedge clk);
        chk("R2", "error single cycle", int'(blow_err), 0);
        chk("R2", "sens unchanged", int'(sens_code), 7);
        chk("R2", "factory unchanged", int'(factory_code), 0);
        chk("R2", "offs unchanged", int'(offs_code), 0);
        chk("R2", "margin unchanged", int'(margin_code), 0);
    endtask

    task automatic t_offset;
        blow_ok("R5", 2'd1, 4'd0);
        blow_ok("R5", 2'd1, 4'd3);
        blow_ok("R5", 2'd1, 4'd5);
        chk("R5", "offs code", int'(offs_code), 9);
        chk("R5", "clamp disable", int'(clamp_dis), 1);
    endtask

    task automatic t_try;
        @(negedge clk);
        try_we = 1'b1; try_reg = 2'd0; try_code = 9'h030;
        @(negedge clk);
        try_reg = 2'd2; try_code = 9'h0FF;
        chk("R7", "sens try overlay OR", int'(sens_code), 'h37);
        @(negedge clk);
        try_we = 1'b0;
        chk("R7", "factory try ignored", int'(factory_code), 0);
    endtask

    task automatic t_readback;
        @(negedge clk);
        rd_reg = 2'd0; rd_bit = 4'd0;
        @(negedge clk);
        chk("R11", "sens bit0 fuse", int'(rd_data), 1);
        rd_bit = 4'd4;
        @(negedge clk);
        chk("R11", "try-only bit reads 0", int'(rd_data), 0);
        rd_reg = 2'd1; rd_bit = 4'd5;
        @(negedge clk);
        chk("R11", "offs bit5 fuse", int'(rd_data), 1);
        rd_bit = 4'd12;
        @(negedge clk);
        chk("R11", "out of range reads 0", int'(rd_data), 0);
    endtask

    task automatic t_power_cycle;
        @(negedge clk);
        pwr_cycle = 1'b1;
        @(negedge clk);
        pwr_cycle = 1'b0;
        chk("R8", "try cleared, fuse kept", int'(sens_code), 7);
        chk("R8", "offs fuse kept", int'(offs_code), 9);
        issue_blow(2'd3, 4'd0);
        pwr_cycle = 1'b1;
        @(negedge clk);
        pwr_cycle = 1'b0;
        repeat (BURN + 1) begin
            @(negedge clk);
            chk("R8", "aborted blow gives no done", int'(blow_done), 0);
        end
        chk("R8", "aborted fuse not set", int'(margin_code), 0);
    endtask

    task automatic t_margin_lock;
        blow_ok("R6", 2'd3, 4'd0);
        blow_ok("R6", 2'd3, 4'd1);
        blow_ok("R6", 2'd3, 4'd2);
        chk("R6", "margin bits", int'(margin_code), 7);
        blow_ok("R6", 2'd3, 4'd8);
        chk("R6", "lock bit in margin", int'(margin_code), 'h107);
        chk("R9", "lock armed", int'(lock_armed), 1);
        chk("R9", "not final yet", int'(final_lock), 0);
        blow_ok("R9", 2'd0, 4'd5);
        chk("R9", "final lock set", int'(final_lock), 1);
        chk("R9", "addressed bit not set", int'(sens_code), 7);
    endtask

    task automatic t_sealed;
        issue_blow(2'd1, 4'd1);
        chk("R10", "no busy when sealed", int'(busy), 0);
        repeat (BURN + 1) begin
            @(negedge clk);
            chk("R10", "no done when sealed", int'(blow_done), 0);
            chk("R10", "no err when sealed", int'(blow_err), 0);
        end
        chk("R10", "offs unchanged", int'(offs_code), 9);
        @(negedge clk);
        try_we = 1'b1; try_reg = 2'd0; try_code = 9'h010;
        @(negedge clk);
        try_we = 1'b0;
        chk("R10", "try ignored when sealed", int'(sens_code), 7);
        pwr_cycle = 1'b1;
        @(negedge clk);
        pwr_cycle = 1'b0;
        chk("R10", "seal survives power cycle", int'(final_lock), 1);
        rd_reg = 2'd3; rd_bit = 4'd8;
        @(negedge clk);
        chk("R10", "read-back after seal", int'(rd_data), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sens_accumulate();
        t_busy_ignore();
        t_reject(2'd0, 4'd6);
        t_reject(2'd2, 4'd0);
        t_reject(2'd1, 4'd6);
        t_reject(2'd3, 4'd9);
        t_offset();
        t_try();
        t_readback();
        t_power_cycle();
        t_margin_lock();
        t_sealed();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule